// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the fifteen general registers R0 to R14 of a 32-bit processor core. The upper registers have private copies for several processor modes. The fast-interrupt mode owns private copies of R8 through R14. The interrupt, supervisor, abort and undefined modes each own only private copies of R13 and R14, and share R8 to R12 with user mode. System mode uses the user copies. Any mode code without a defined meaning selects a scratch bank. In that bank R8 to R14 start at zero, and the bank is wiped when the core leaves it. The program counter, the status registers and exception entry are handled outside the block.

The core drives the new mode code together with a one-cycle change strobe. The two read ports and the write port always work on the registers of the current mode. A fourth port reads or writes the copy of a register that belongs to any named mode, which a core uses for user-mode block transfers or for debug. Each register copy lives in its own fixed storage slot, and a mode change only changes which slot each register name selects. So a mode change finishes at one clock edge and no data is copied.

Top module: `rbank_regfile`

## Requirements
- R1: After reset every register copy in every bank reads as zero, and the current bank is the user bank.
- R2: R0 to R7 are one set of registers shared by all modes. Address 15 always reads zero on every read port, and a write to address 15 changes nothing.
- R3: Mode code 0x11 or 0x01 selects the fast-interrupt bank, which has private copies of R8 to R14. The user copies of R8 to R12 keep their values while that bank is current and can be read again after leaving it.
- R4: Mode codes 0x12/0x02, 0x13/0x03, 0x17 and 0x1B select the interrupt, supervisor, abort and undefined banks. Each has private R13 and R14 and uses the user R8 to R12. Codes 0x10, 0x00 and 0x1F select the user bank.
- R5: Every other 5-bit code selects the scratch bank. Its R8 to R14 read zero on entry and can be written while it is current. All seven are cleared at the clock edge where the core moves to a different bank.
- R6: Reads are combinational on the current bank. A mode strobe makes the new bank current from the next clock edge. A write in the same cycle as the strobe goes to the old bank.
- R7: The cross-mode port reads and writes the copy of its register that belongs to the bank of its mode code. When that bank is the current one, this is the live register. If it names the scratch bank while the scratch bank is not current, R8 to R14 read zero and writes are dropped.
- R8: If the main write port and the cross-mode port write the same storage in one cycle, the main write port's value is kept.
- R9: A mode change never alters any stored value except the scratch-bank wipe. This includes a change between two codes of the same bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 5 | Mode code taken when the strobe is high |
| mode_chg_i | input | 1 | Mode change strobe |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | DW | Read port A data, current bank |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | DW | Read port B data, current bank |
| wr_en_i | input | 1 | Main write enable |
| wr_addr_i | input | 4 | Main write register number |
| wr_data_i | input | DW | Main write data |
| x_mode_i | input | 5 | Mode code whose copy the cross-mode port reaches |
| x_addr_i | input | 4 | Cross-mode register number |
| x_we_i | input | 1 | Cross-mode write enable |
| x_wdata_i | input | DW | Cross-mode write data |
| x_rdata_o | output | DW | Cross-mode read data |

## Verification
Two functions can land on the same clock edge: a mode change, and a write from the main port or the cross-mode port. A write at that edge must land in the bank that was current before the change. This includes a final write into the scratch bank at the edge where the wipe happens. The bench triggers this case on every ordered pair of mode codes, including the scratch codes, by writing R9 in the cycle of the strobe. It then reads every register from the new bank and through every mode on the cross-mode port. A random phase adds main and cross-mode writes to the same register in the same cycle. Each result is compared with a model of seven banks by fifteen registers that copies registers on each mode change, which is a different method from the slot selection in the hardware.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
    typedef enum logic [2:0] {
        BK_USR, BK_FIQ, BK_IRQ, BK_SVC, BK_ABT, BK_UND, BK_DUM
    } bank_e;

    localparam int NUM_LIVE  = 15;           // R0..R14 held here
    localparam int FIQ_BASE  = NUM_LIVE;     // fast-interrupt R8..R14
    localparam int PRIV_BASE = FIQ_BASE + 7; // IRQ/SVC/ABT/UND R13..R14
    localparam int DUM_BASE  = PRIV_BASE + 8;// scratch R8..R14
    localparam int NSLOT     = DUM_BASE + 7;
    localparam int SLOT_W    = $clog2(NSLOT);
endpackage

// File: rtl/rbank_mode_map.sv
module rbank_mode_map
    import rbank_pkg::*;
(
    input  logic [4:0] mode_i,
    output bank_e      bank_o
);
    always_comb begin
        case (mode_i)
            5'h00, 5'h10, 5'h1F: bank_o = BK_USR;
            5'h01, 5'h11:        bank_o = BK_FIQ;
            5'h02, 5'h12:        bank_o = BK_IRQ;
            5'h03, 5'h13:        bank_o = BK_SVC;
            5'h17:               bank_o = BK_ABT;
            5'h1B:               bank_o = BK_UND;
            default:             bank_o = BK_DUM;
        endcase
    end
endmodule

// File: rtl/rbank_slot.sv
module rbank_slot
    import rbank_pkg::*;
(
    input  bank_e             bank_i,
    input  logic [3:0]        reg_i,
    output logic              ok_o,
    output logic [SLOT_W-1:0] idx_o
);
    int n;
    int sel;

    always_comb begin
        n     = int'(reg_i);
        ok_o  = (reg_i != 4'hF);
        sel   = n;
        if (n >= 8 && n <= 12) begin
            if (bank_i == BK_FIQ)      sel = FIQ_BASE + n - 8;
            else if (bank_i == BK_DUM) sel = DUM_BASE + n - 8;
        end else if (n >= 13 && n <= 14) begin
            case (bank_i)
                BK_USR:  sel = n;
                BK_FIQ:  sel = FIQ_BASE + n - 8;
                BK_DUM:  sel = DUM_BASE + n - 8;
                default: sel = PRIV_BASE + 2 * (int'(bank_i) - int'(BK_IRQ)) + n - 13;
            endcase
        end else if (n == 15) begin
            sel = 0;
        end
        idx_o = SLOT_W'(sel);
    end
endmodule

// File: rtl/rbank_store.sv
module rbank_store
    import rbank_pkg::*;
#(
    parameter int DW    = 32,
    parameter int NRD   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wa_en_i,
    input  logic [SLOT_W-1:0] wa_slot_i,
    input  logic [DW-1:0]     wa_data_i,
    input  logic              wb_en_i,
    input  logic [SLOT_W-1:0] wb_slot_i,
    input  logic [DW-1:0]     wb_data_i,
    input  logic              clr_i,
    input  logic [SLOT_W-1:0] rd_slot_i [NRD],
    output logic [DW-1:0]     rd_data_o [NRD]
);
    logic [DW-1:0] mem_d [NSLOT];
    logic [DW-1:0] mem_q [NSLOT];

    always_comb begin
        for (int i = 0; i < NSLOT; i++) mem_d[i] = mem_q[i];
        if (wb_en_i) mem_d[wb_slot_i] = wb_data_i;   // cross port first
        if (wa_en_i) mem_d[wa_slot_i] = wa_data_i;   // main port wins
        if (clr_i) begin
            for (int i = DUM_BASE; i < NSLOT; i++) mem_d[i] = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_data_o[g] = mem_q[rd_slot_i[g]];
    end

    // main-port data survives a same-cycle cross write (R8)
    p_main_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wa_en_i && !(clr_i && wa_slot_i >= SLOT_W'(DUM_BASE))
        |=> mem_q[$past(wa_slot_i)] == $past(wa_data_i));

    // scratch bank wiped on exit (R5)
    p_scratch_wiped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (mem_q[DUM_BASE] == '0) && (mem_q[NSLOT-1] == '0));

    // no write, no wipe: stored user R8 untouched (R9)
    p_idle_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !wa_en_i && !wb_en_i && !clr_i |=> $stable(mem_q[8]));
endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [4:0]    mode_i,
    input  logic          mode_chg_i,
    input  logic [3:0]    rd_a_addr_i,
    output logic [DW-1:0] rd_a_data_o,
    input  logic [3:0]    rd_b_addr_i,
    output logic [DW-1:0] rd_b_data_o,
    input  logic          wr_en_i,
    input  logic [3:0]    wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic [4:0]    x_mode_i,
    input  logic [3:0]    x_addr_i,
    input  logic          x_we_i,
    input  logic [DW-1:0] x_wdata_i,
    output logic [DW-1:0] x_rdata_o
);
    localparam int NPORT = 4;   // read A, read B, write, cross
    localparam int NRD   = 3;

    typedef struct packed {
        bank_e bank;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    bank_e new_bank, x_bank;
    logic  clr;
    logic  x_ok;

    bank_e             sel_bank [NPORT];
    logic [3:0]        sel_reg  [NPORT];
    logic              slot_ok  [NPORT];
    logic [SLOT_W-1:0] slot_idx [NPORT];
    logic [SLOT_W-1:0] rd_slot  [NRD];
    logic [DW-1:0]     rd_data  [NRD];

    rbank_mode_map u_map_new (.mode_i(mode_i),   .bank_o(new_bank));
    rbank_mode_map u_map_x   (.mode_i(x_mode_i), .bank_o(x_bank));

    assign sel_bank[0] = ctl_q.bank;  assign sel_reg[0] = rd_a_addr_i;
    assign sel_bank[1] = ctl_q.bank;  assign sel_reg[1] = rd_b_addr_i;
    assign sel_bank[2] = ctl_q.bank;  assign sel_reg[2] = wr_addr_i;
    assign sel_bank[3] = x_bank;      assign sel_reg[3] = x_addr_i;

    for (genvar g = 0; g < NPORT; g++) begin : g_slot
        rbank_slot u_slot (
            .bank_i(sel_bank[g]), .reg_i(sel_reg[g]),
            .ok_o(slot_ok[g]),    .idx_o(slot_idx[g])
        );
    end

    assign rd_slot[0] = slot_idx[0];
    assign rd_slot[1] = slot_idx[1];
    assign rd_slot[2] = slot_idx[3];

    always_comb begin
        ctl_d = ctl_q;
        if (mode_chg_i) ctl_d.bank = new_bank;
        clr  = mode_chg_i && (ctl_q.bank == BK_DUM) && (new_bank != BK_DUM);
        x_ok = slot_ok[3] &&
               !((x_bank == BK_DUM) && (ctl_q.bank != BK_DUM) && (x_addr_i >= 4'd8));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q.bank <= BK_USR;
        else        ctl_q      <= ctl_d;
    end

    rbank_store #(.DW(DW), .NRD(NRD)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wa_en_i(wr_en_i && slot_ok[2]), .wa_slot_i(slot_idx[2]), .wa_data_i(wr_data_i),
        .wb_en_i(x_we_i && x_ok),        .wb_slot_i(slot_idx[3]), .wb_data_i(x_wdata_i),
        .clr_i(clr), .rd_slot_i(rd_slot), .rd_data_o(rd_data)
    );

    assign rd_a_data_o = slot_ok[0] ? rd_data[0] : '0;
    assign rd_b_data_o = slot_ok[1] ? rd_data[1] : '0;
    assign x_rdata_o   = x_ok       ? rd_data[2] : '0;

    // bank only moves on a strobe (R6)
    p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_chg_i |=> $stable(ctl_q.bank));

    // the strobe's bank is current after the edge (R6)
    p_bank_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg_i |=> ctl_q.bank == $past(new_bank));

    // address 15 reads zero (R2)
    p_r15_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_addr_i == 4'hF |-> rd_a_data_o == '0);

    // scratch bank out of reach from outside reads zero (R7)
    p_cross_scratch_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_bank == BK_DUM) && (ctl_q.bank != BK_DUM) && (x_addr_i >= 4'd8)
        |-> x_rdata_o == '0);
endmodule

// File: tb/rbank_regfile_tb.sv
`timescale 1ns/1ps
module rbank_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode_i = '0;
    logic        mode_chg_i = 1'b0;
    logic [3:0]  rd_a_addr_i = '0, rd_b_addr_i = '0, wr_addr_i = '0, x_addr_i = '0;
    logic [31:0] rd_a_data_o, rd_b_data_o, x_rdata_o;
    logic        wr_en_i = 1'b0, x_we_i = 1'b0;
    logic [31:0] wr_data_i = '0, x_wdata_i = '0;
    logic [4:0]  x_mode_i = '0;

    always #4 clk = ~clk;

    rbank_regfile #(.DW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .mode_chg_i(mode_chg_i),
        .rd_a_addr_i(rd_a_addr_i), .rd_a_data_o(rd_a_data_o),
        .rd_b_addr_i(rd_b_addr_i), .rd_b_data_o(rd_b_data_o),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .x_mode_i(x_mode_i), .x_addr_i(x_addr_i), .x_we_i(x_we_i),
        .x_wdata_i(x_wdata_i), .x_rdata_o(x_rdata_o)
    );

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    // reference: live registers plus 7 banks x 15 saved registers
    logic [31:0] live [15];
    logic [31:0] st   [7][15];
    int          cur  = 0;

    localparam logic [4:0] MODES [13] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B,
        5'h1F, 5'h00, 5'h01, 5'h02, 5'h03, 5'h14, 5'h05};

    function automatic int bank_of(logic [4:0] m);
        if (m == 5'h1F) return 0;
        if (m[3:2] == 2'b00 && m[1:0] <= 2'd3 && m[3:0] < 4) return int'(m[1:0]);
        if (m == 5'h17) return 4;
        if (m == 5'h1B) return 5;
        return 6;
    endfunction

    function automatic int owner(int b, int r);
        if (r < 8) return 0;
        if (r < 13) return (b == 1 || b == 6) ? b : 0;
        return b;
    endfunction

    function automatic logic [31:0] m_xread(int xb, int r);
        int o;
        if (r == 15) return '0;
        o = owner(xb, r);
        if (o == owner(cur, r)) return live[r];
        if (o == 6) return '0;
        return st[o][r];
    endfunction

    task automatic m_switch(int nb);
        if (nb == cur) return;
        for (int r = 8; r < 15; r++) st[owner(cur, r)][r] = live[r];
        if (cur == 6) for (int r = 0; r < 15; r++) st[6][r] = '0;
        for (int r = 8; r < 15; r++) live[r] = st[owner(nb, r)][r];
        cur = nb;
    endtask

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic chg, input logic [4:0] nm,
                        input logic we, input logic [3:0] wa, input logic [31:0] wd,
                        input logic [3:0] ra, input logic [3:0] rb,
                        input logic xwe, input logic [4:0] xm, input logic [3:0] xa,
                        input logic [31:0] xd, input string req);
        int xb, o;
        @(negedge clk);
        mode_chg_i = chg; mode_i = nm; wr_en_i = we; wr_addr_i = wa; wr_data_i = wd;
        rd_a_addr_i = ra; rd_b_addr_i = rb; x_we_i = xwe; x_mode_i = xm;
        x_addr_i = xa; x_wdata_i = xd;
        #1;
        xb = bank_of(xm);
        check(req, "read A", rd_a_data_o, (ra == 4'hF) ? 32'h0 : live[ra]);
        check(req, "read B", rd_b_data_o, (rb == 4'hF) ? 32'h0 : live[rb]);
        check(req, "cross read", x_rdata_o, m_xread(xb, int'(xa)));
        @(posedge clk);
        if (xwe && xa != 4'hF) begin
            o = owner(xb, int'(xa));
            if (o == owner(cur, int'(xa))) live[xa] = xd;
            else if (o != 6) st[o][xa] = xd;
        end
        if (we && wa != 4'hF) live[wa] = wd;
        if (chg) m_switch(bank_of(nm));
    endtask

    task automatic finish_run();
        if (done) return;
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < 15; r++) begin
            live[r] = '0;
            for (int b = 0; b < 7; b++) st[b][r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: everything zero after reset, user bank current
        for (int r = 0; r < 16; r++)
            step(0, 0, 0, 0, 0, 4'(r), 4'(15 - r), 0, 5'h11, 4'(r % 15), 0, "R1");

        // R2: R15 write dropped, reads zero; low registers shared
        step(0, 0, 1, 4'hF, 32'hDEAD_BEEF, 4'hF, 4'hF, 1, 5'h13, 4'hF, 32'h1234, "R2");
        step(0, 0, 1, 4'd3, 32'h0000_0333, 4'hF, 4'd3, 0, 5'h11, 4'd3, 0, "R2");
        step(1, 5'h11, 0, 0, 0, 4'd3, 4'hF, 0, 5'h12, 4'd3, 0, "R2");
        step(1, 5'h10, 0, 0, 0, 4'd3, 4'hF, 0, 5'h1B, 4'd3, 0, "R2");

        // R8: main and cross write to user R10 in the same cycle
        step(0, 0, 1, 4'd10, 32'hAAAA_0001, 4'd10, 4'd0, 1, 5'h12, 4'd10, 32'hBBBB_0002, "R8");
        step(0, 0, 0, 0, 0, 4'd10, 4'd10, 0, 5'h1F, 4'd10, 0, "R8");

        // R9: same-bank mode change keeps values
        step(1, 5'h1F, 1, 4'd13, 32'h5151_1313, 4'd10, 4'd13, 0, 5'h10, 4'd13, 0, "R9");
        step(1, 5'h00, 0, 0, 0, 4'd13, 4'd10, 0, 5'h1F, 4'd13, 0, "R9");

        // every ordered mode pair, R9 written on the strobe edge
        for (int i = 0; i < 13; i++) begin
            for (int j = 0; j < 13; j++) begin
                string rq;
                int tb = bank_of(MODES[j]);
                rq = (tb == 1) ? "R3" : (tb == 6) ? "R5" : "R4";
                step(1, MODES[i], 0, 0, 0, 4'd0, 4'd8, 0, MODES[i], 4'd8, 0, rq);
                for (int r = 0; r < 15; r++)
                    step(0, 0, 1, 4'(r), 32'(i * 65536 + j * 256 + r) ^ 32'hC0DE_0000,
                         4'(r), 4'd14, 0, MODES[j], 4'(r), 0, rq);
                step(1, MODES[j], 1, 4'd9, 32'h9999_0000 | 32'(i * 16 + j),
                     4'd9, 4'd13, 0, MODES[i], 4'd9, 0, "R6");
                for (int r = 0; r < 8; r++)
                    step(0, 0, 0, 0, 0, 4'(r), 4'(r + 8), 0, MODES[i], 4'(r + 7), 0,
                         (r == 0) ? "R6" : rq);
                for (int m = 0; m < 13; m++)
                    for (int r = 8; r < 15; r++)
                        step(0, 0, 0, 0, 0, 4'(r), 4'(m), 0, MODES[m], 4'(r), 0, "R7");
            end
        end

        // random mix of strobes, writes and cross accesses
        for (int k = 0; k < 3000; k++) begin
            logic [4:0] nm = ($urandom % 4 == 0) ? 5'($urandom) : MODES[$urandom % 13];
            logic [3:0] wa = 4'($urandom);
            logic [3:0] xa = ($urandom % 3 == 0) ? wa : 4'($urandom);
            step(($urandom % 4) == 0, nm, ($urandom % 2) == 0, wa, $urandom,
                 4'($urandom), 4'($urandom), ($urandom % 3) == 0,
                 MODES[$urandom % 13], xa, $urandom, "R7");
        end

        finish_run();
    end
endmodule